// File: doc/BRIEF.md
# Single-Register 16-Bit Accumulator Shifter

This block shifts one 16-bit accumulator value by 0 to 15 places. It offers eight modes: arithmetic, open logical, linked through carry, and closed rotate, each one in both directions. A start pulse captures the operand, the mode, the incoming carry and the count. The block then moves one bit per clock. A one-cycle done pulse presents the result together with the status updates it produces.

The count has two sources. One is a 4-bit immediate field. The other is the low four bits of a register value that the surrounding datapath has already read. The block does not hold the status register. It reports a new carry together with a write enable for it, a set request for overflow, and the odd, zero and negative flags taken from the result. The caller merges these into its own status word.

Top module: `acc_shifter`

## Requirements
- R1: When `cnt_sel` is 1 the shift count is `imm_cnt`. When it is 0 the count is `reg_cnt[3:0]` and the upper bits of `reg_cnt` are ignored.
- R2: Op 0 shifts left and fills bit 0 with zero. Op 4 shifts right and copies bit 15 into the vacated positions.
- R3: Op 2 shifts left and op 6 shifts right, both filling with zeros. Op 3 rotates left and op 7 rotates right, over the 16 bits only.
- R4: Op 1 rotates left and op 5 rotates right, over the 17-bit value formed by `carry_in` above the operand. The carry ends as the 17th bit of that rotation.
- R5: For a nonzero count, `carry_we` is 1 for ops 0, 1, 4 and 5. `carry_out` is then:
  - for ops 0 and 1, the last bit shifted out of bit 15;
  - for op 5, the last bit shifted out of bit 0;
  - for op 4, zero.
- R6: Ops 2, 3, 6 and 7 never raise `carry_we`.
- R7: `ovf_set` is 1 at done only for op 0 with a nonzero count. It is 1 when, on at least one step, bit 15 differed from bit 14 just before that step. Otherwise `ovf_set` is 0, which means overflow is left unchanged.
- R8: While done is high:
  - `flag_od` equals result bit 0;
  - `flag_ze` is 1 exactly when the result is zero;
  - `flag_ng` equals result bit 15.
- R9: A count of zero returns the operand unchanged, with `carry_we` and `ovf_set` both 0. Done follows in the cycle after the start edge.
- R10: Take the start edge as the first clock edge. For a count n, `done` is high for exactly one cycle, in the cycle after the (n+1)th rising edge. The result and flags hold until the next accepted start.
- R11: A start that arrives while `busy` is high is ignored. A start in the cycle where `done` is high is accepted.
- R12: After reset, `done`, `busy`, `carry_we` and `ovf_set` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a shift |
| operand | input | 16 | Value to shift |
| op | input | 3 | Shift mode, encoded as in R2 to R4 |
| cnt_sel | input | 1 | 1 selects the immediate count, 0 selects the register count |
| imm_cnt | input | 4 | Immediate count |
| reg_cnt | input | 16 | Register value; only bits 3:0 are used as the count |
| carry_in | input | 1 | Current carry flag |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted value |
| carry_we | output | 1 | Carry flag must be written |
| carry_out | output | 1 | New carry value |
| ovf_set | output | 1 | Overflow flag must be set |
| flag_od | output | 1 | Odd flag |
| flag_ze | output | 1 | Zero flag |
| flag_ng | output | 1 | Negative flag |

## Verification
A completion pulse and the acceptance of the next start can happen in the same cycle. The bench therefore drives a new start in the very cycle where it observes `done`. This includes a zero-count follow-up, which has to produce a second done pulse right after the first. The bench judges both operations against its own model, and checks that the second one did not disturb the first result it had already sampled. It also injects a start partway through a long shift and confirms that the first operation's result is unchanged.

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] operand,
  input  logic [2:0]       op,
  input  logic             cnt_sel,
  input  logic [3:0]       imm_cnt,
  input  logic [WIDTH-1:0] reg_cnt,
  input  logic             carry_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             carry_we,
  output logic             carry_out,
  output logic             ovf_set,
  output logic             flag_od,
  output logic             flag_ze,
  output logic             flag_ng
);
  localparam int CW = 4;

  logic [WIDTH-1:0] acc, nxt_acc;
  logic [2:0]       op_q;
  logic [CW-1:0]    cnt, n_sel;
  logic             cy, nxt_cy, step_ov, cwe_q, ov_q;
  logic             carry_mode;

  assign n_sel      = cnt_sel ? imm_cnt : reg_cnt[CW-1:0];
  assign carry_mode = ~op_q[1];

  always_comb begin
    nxt_acc = acc;
    nxt_cy  = cy;
    step_ov = 1'b0;
    case (op_q)
      3'd0: begin
        nxt_acc = {acc[WIDTH-2:0], 1'b0};
        nxt_cy  = acc[WIDTH-1];
        step_ov = acc[WIDTH-1] ^ acc[WIDTH-2];
      end
      3'd1: begin
        nxt_acc = {acc[WIDTH-2:0], cy};
        nxt_cy  = acc[WIDTH-1];
      end
      3'd2: nxt_acc = {acc[WIDTH-2:0], 1'b0};
      3'd3: nxt_acc = {acc[WIDTH-2:0], acc[WIDTH-1]};
      3'd4: begin
        nxt_acc = {acc[WIDTH-1], acc[WIDTH-1:1]};
        nxt_cy  = 1'b0;
      end
      3'd5: begin
        nxt_acc = {cy, acc[WIDTH-1:1]};
        nxt_cy  = acc[0];
      end
      3'd6: nxt_acc = {1'b0, acc[WIDTH-1:1]};
      default: nxt_acc = {acc[0], acc[WIDTH-1:1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      op_q  <= '0;
      cnt   <= '0;
      cy    <= 1'b0;
      cwe_q <= 1'b0;
      ov_q  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc   <= operand;
          op_q  <= op;
          cy    <= carry_in;
          cwe_q <= 1'b0;
          ov_q  <= 1'b0;
          cnt   <= n_sel;
          if (n_sel == '0) done <= 1'b1;
          else             busy <= 1'b1;
        end
      end else begin
        acc   <= nxt_acc;
        cy    <= nxt_cy;
        cwe_q <= carry_mode;
        ov_q  <= ov_q | step_ov;
        cnt   <= cnt - 1'b1;
        if (cnt == 1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result    = acc;
  assign carry_out = cy;
  assign carry_we  = cwe_q;
  assign ovf_set   = ov_q;
  assign flag_od   = acc[0];
  assign flag_ze   = (acc == '0);
  assign flag_ng   = acc[WIDTH-1];

  AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && n_sel == '0) |=> (done && result == $past(operand) && !carry_we && !ovf_set)); // R9
  AST_RIGHT_ARITH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && carry_we && op_q == 3'd4) |-> !carry_out); // R5
  AST_LOGICAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1]) |-> !carry_we); // R6
  AST_OVF_ONLY_LEFT_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> (op_q == 3'd0)); // R7
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt > 1) |=> (busy && op_q == $past(op_q))); // R11
endmodule

// File: tb/sim_acc_shifter.sv
module sim_acc_shifter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] operand;
  logic [2:0]  op;
  logic        cnt_sel;
  logic [3:0]  imm_cnt;
  logic [15:0] reg_cnt;
  logic        carry_in;
  logic        busy, done, carry_we, carry_out, ovf_set, flag_od, flag_ze, flag_ng;
  logic [15:0] result;

  int total = 0;
  int fails = 0;

  logic [15:0] e_res;
  logic        e_cy, e_we, e_ov;
  int          e_n;

  always #5 clk = ~clk;

  acc_shifter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .op(op),
    .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .carry_in(carry_in),
    .busy(busy), .done(done), .result(result), .carry_we(carry_we),
    .carry_out(carry_out), .ovf_set(ovf_set), .flag_od(flag_od),
    .flag_ze(flag_ze), .flag_ng(flag_ng)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [15:0] v, input logic ci, input int n);
    logic [15:0] r;
    logic c, ov;
    r = v; c = ci; ov = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0: begin ov = ov | (r[15] ^ r[14]); c = r[15]; r = {r[14:0], 1'b0}; end
        3'd1: begin logic t; t = r[15]; r = {r[14:0], c}; c = t; end
        3'd2: r = {r[14:0], 1'b0};
        3'd3: r = {r[14:0], r[15]};
        3'd4: begin c = 1'b0; r = {r[15], r[15:1]}; end
        3'd5: begin logic t; t = r[0]; r = {c, r[15:1]}; c = t; end
        3'd6: r = {1'b0, r[15:1]};
        default: r = {r[0], r[15:1]};
      endcase
    end
    e_res = r;
    e_we  = (n != 0) && !o[1];
    e_cy  = c;
    e_ov  = (o == 3'd0) && ov;
  endtask

  task automatic drive(input logic [2:0] o, input logic [15:0] v, input logic ci,
                       input logic sel, input logic [3:0] im, input logic [15:0] rg);
    op = o; operand = v; carry_in = ci; cnt_sel = sel; imm_cnt = im; reg_cnt = rg;
    start = 1'b1;
    e_n = sel ? int'(im) : int'(rg[3:0]);
    model(o, v, ci, e_n);
  endtask

  task automatic wait_check(input bit intrude);
    int k;
    logic [15:0] x_res;
    logic x_cy, x_we, x_ov;
    int x_n;
    x_res = e_res; x_cy = e_cy; x_we = e_we; x_ov = e_ov; x_n = e_n;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1'b0;
      if (intrude && k == 2) begin start = 1'b1; operand = ~operand; op = ~op; end
      if (intrude && k == 3) start = 1'b0;
    end while (!done && k < 20);
    check("R10 latency", k, x_n + 1);
    check("R2 R3 R4 R1 result", result, x_res);
    if (intrude) check("R11 start while busy ignored", result, x_res);
    check("R5 R6 carry_we", carry_we, x_we);
    if (x_we) check("R5 carry_out", carry_out, x_cy);
    check("R7 ovf_set", ovf_set, x_ov);
    check("R8 flag_od", flag_od, x_res[0]);
    check("R8 flag_ze", flag_ze, x_res == 16'h0);
    check("R8 flag_ng", flag_ng, x_res[15]);
    e_res = x_res;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] v, input logic ci,
                        input logic sel, input logic [3:0] im, input logic [15:0] rg,
                        input bit intrude);
    logic [15:0] held;
    @(negedge clk);
    drive(o, v, ci, sel, im, rg);
    wait_check(intrude);
    held = e_res;
    @(negedge clk);
    check("R10 done single cycle", done, 1'b0);
    check("R10 result held", result, held);
  endtask

  initial begin
    #2000000;
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; start = 1'b0; operand = '0; op = '0; cnt_sel = 1'b0;
    imm_cnt = '0; reg_cnt = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset done", done, 1'b0);
    check("R12 reset busy", busy, 1'b0);
    check("R12 reset result", result, 16'h0);
    check("R12 reset carry_we", carry_we, 1'b0);
    check("R12 reset ovf_set", ovf_set, 1'b0);
    rst_n = 1'b1;

    // R2 left arithmetic overflow and sign-filling right shift
    run_op(3'd0, 16'h4000, 1'b0, 1'b1, 4'd1, 16'h0, 0);
    run_op(3'd0, 16'h2001, 1'b1, 1'b1, 4'd2, 16'h0, 0);
    run_op(3'd4, 16'h8001, 1'b1, 1'b1, 4'd15, 16'h0, 0);
    // R3 open and closed shifts
    run_op(3'd2, 16'hFFFF, 1'b1, 1'b1, 4'd15, 16'h0, 0);
    run_op(3'd7, 16'h0001, 1'b0, 1'b1, 4'd1, 16'h0, 0);
    run_op(3'd3, 16'h8000, 1'b1, 1'b1, 4'd4, 16'h0, 0);
    // R4 linked shifts through carry
    run_op(3'd1, 16'h8000, 1'b1, 1'b1, 4'd1, 16'h0, 0);
    run_op(3'd5, 16'h0001, 1'b0, 1'b1, 4'd1, 16'h0, 0);
    // R1 register count uses only the low bits
    run_op(3'd6, 16'hF0F0, 1'b0, 1'b0, 4'd9, 16'hFFF3, 0);
    // R9 zero count
    run_op(3'd0, 16'h4000, 1'b1, 1'b1, 4'd0, 16'h0, 0);
    run_op(3'd5, 16'h0000, 1'b1, 1'b0, 4'd7, 16'h1230, 0);
    // R11 start while busy ignored
    run_op(3'd3, 16'h1234, 1'b0, 1'b1, 4'd6, 16'h0, 1);

    // R11 back-to-back: a new start in the done cycle is accepted
    @(negedge clk);
    drive(3'd1, 16'hA5A5, 1'b1, 1'b1, 4'd3, 16'h0);
    wait_check(0);
    drive(3'd2, 16'h0F0F, 1'b0, 1'b1, 4'd0, 16'h0);
    wait_check(0);
    drive(3'd4, 16'h8F00, 1'b1, 1'b0, 4'd0, 16'h0005);
    wait_check(0);
    @(negedge clk);
    check("R10 done single cycle after chain", done, 1'b0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      run_op(a[2:0], b[15:0], a[3], a[4], a[8:5], {b[31:20], a[12:9]}, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule